// File: doc/BRIEF.md
# Timestamp Histogram Engine

The engine builds a histogram of fine time codes while acquisition is running, so that only the finished histogram has to leave the chip instead of every timestamp. Each arriving code is shifted by a constant offset chosen per input channel, which lines the channels up in time. It can then be folded into a coarser bin by a programmable merge shift before the matching counter is incremented.

Two histogram banks alternate. One bank collects hits while the other is read out. A swap command exchanges their roles and empties the bank that takes over collection. A read-out pass streams the idle bank in one of two forms. The raw form gives one beat per raw bin. The calibrated form redistributes raw counts into a smaller set of equal-width bins, using a preloaded table that holds a fractional weight and an index step for every raw bin. The table itself is computed elsewhere.

Configuration uses a write-only port selected by `cfg_sel`: 0 sets the merge shift, 1 sets a channel offset, 2 writes a calibration table entry and 3 sets the read-out mode.

Top module: `hist_engine`

## Requirements
- R1: After reset, `rd_valid` stays low until a read-out is requested, the read-out mode is raw, and every bin of both banks reads as zero.
- R2: Every cycle with `ts_valid` high adds one to a bin of the collecting bank. The bin index is ((`ts_code` + offset of `ts_chan`) mod 1024) shifted right by the merge shift. The count is visible in a later read-out of that bank.
- R3: A write with `cfg_sel`=0 sets the merge shift from `cfg_data[3:0]`. Values above MAX_SHIFT (4) are clamped to 4. The shift applies to hits that arrive after the write.
- R4: A write with `cfg_sel`=1 sets the offset of channel `cfg_idx`. The offset is `cfg_data` read as a 10-bit two's complement number, and the sum wraps modulo 1024.
- R5: Hits to the same bin on consecutive cycles are all counted. None is lost to the read-modify-write latency.
- R6: A bin counter saturates at 65535 and does not wrap.
- R7: A `cmd_clear` pulse zeroes the collecting bank in one cycle. A `cmd_swap` pulse makes the collecting bank the read-out bank, and the other bank becomes the collecting bank, starting from zero.
- R8: In raw mode (`cfg_sel`=3, `cfg_data[0]`=0), a `rd_start` pulse streams the read-out bank as 1024 beats, one per cycle, with indices 0 to 1023 in ascending order. `rd_last` is high only on index 1023.
- R9: In calibrated mode (`cfg_data[0]`=1), table entry `cfg_idx` is written through `cfg_sel`=2, with `cfg_data[8]` as the step and `cfg_data[7:0]` as the weight w.
    - The calibrated index of raw bin r is the sum of the steps of raw bins 1 to r. The step of raw bin 0 is ignored.
    - floor(count·w/256) of the count goes to that calibrated bin and the remainder goes to the next one. A share that would land beyond bin 799 is dropped.
    - The pass emits 800 beats with indices 0 to 799 in ascending order. `rd_last` is high on index 799.
- R10: Hits that arrive during a read-out pass go to the collecting bank and do not change any beat of the pass.
- R11: A `rd_start` pulse that arrives during a pass is ignored. The stream continues unchanged, and no second pass follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | Timestamp present this cycle |
| ts_chan | input | 2 | Channel of the timestamp |
| ts_code | input | 10 | Fine time code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 shift, 1 offset, 2 table, 3 mode |
| cfg_idx | input | 10 | Channel or raw-bin index of the write |
| cfg_data | input | 10 | Write data |
| cmd_clear | input | 1 | Zero the collecting bank |
| cmd_swap | input | 1 | Exchange banks and zero the new collecting bank |
| rd_start | input | 1 | Start a read-out pass of the idle bank |
| rd_valid | output | 1 | Read-out beat present |
| rd_idx | output | 10 | Bin index of the beat |
| rd_data | output | 20 | Bin content of the beat |
| rd_last | output | 1 | Final beat of the pass |

## Verification
The bench sends bursts of hits to one bin on consecutive cycles. Without the forwarding path, such a burst would lose roughly every second count. A long burst to a single bin is pushed past full scale, where a wrapping counter would read back as a small number. Offsets are chosen to wrap across both ends of the code range, and an oversized merge shift is written to show whether it is clamped.

In calibrated mode, the table sets a step on raw bin 0 that must be ignored. The steps also drive the last calibrated index to 799, so a remainder falls off the end. An off-by-one in the index walk would shift every beat, or emit 801 beats. Hits that arrive in the middle of a pass, together with a second start request, expose a design that reads the wrong bank or restarts its stream.

// File: rtl/hist_pkg.sv
package hist_pkg;
   typedef enum logic [1:0] {
      CFG_SHIFT  = 2'd0,
      CFG_OFFSET = 2'd1,
      CFG_CALTAB = 2'd2,
      CFG_MODE   = 2'd3
   } cfg_sel_e;

   typedef enum logic [1:0] {
      RO_IDLE  = 2'd0,
      RO_SCAN  = 2'd1,
      RO_FLUSH = 2'd2
   } ro_state_e;
endpackage

// File: rtl/hist_bin_map.sv
module hist_bin_map #(
   parameter int AW        = 10,
   parameter int N_CH      = 4,
   parameter int CH_W      = 2,
   parameter int MAX_SHIFT = 4,
   parameter int SW        = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_we,
   input  logic [3:0]    shift_req,
   input  logic          off_we,
   input  logic [CH_W-1:0] off_ch,
   input  logic [AW-1:0] off_val,
   input  logic          ts_valid,
   input  logic [CH_W-1:0] ts_ch,
   input  logic [AW-1:0] ts_code,
   output logic          bin_valid,
   output logic [AW-1:0] bin_addr
);
   logic [SW-1:0] shift_q;
   logic [AW-1:0] off_q [N_CH];
   logic [AW-1:0] adj;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         for (int i = 0; i < N_CH; i++) off_q[i] <= '0;
      end else begin
         if (shift_we)
            shift_q <= (shift_req > 4'(MAX_SHIFT)) ? SW'(MAX_SHIFT) : SW'(shift_req);
         if (off_we)
            off_q[off_ch] <= off_val;
      end
   end

   assign adj = ts_code + off_q[ts_ch];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bin_valid <= 1'b0;
         bin_addr  <= '0;
      end else begin
         bin_valid <= ts_valid;
         bin_addr  <= adj >> shift_q;
      end
   end

   // R2
   hit_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid |=> bin_valid);

   // R3
   merge_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bin_valid |-> ((bin_addr >> (AW - int'($past(shift_q)))) == '0));
endmodule

// File: rtl/hist_bank.sv
module hist_bank #(
   parameter int DEPTH = 1024,
   parameter int AW    = 10,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [AW-1:0]    rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [CNT_W-1:0] wr_data
);
   logic [CNT_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0] live_q;
   logic [CNT_W-1:0] rd_q;
   logic             rd_live_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rd_q <= mem[rd_addr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q    <= '0;
         rd_live_q <= 1'b0;
      end else begin
         rd_live_q <= live_q[rd_addr];
         if (clr) live_q <= '0;
         if (wr_en) live_q[wr_addr] <= 1'b1;
      end
   end

   assign rd_data = rd_live_q ? rd_q : '0;

   // R7
   clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) && !$past(wr_en) |-> live_q == '0);
endmodule

// File: rtl/hist_accum.sv
module hist_accum #(
   parameter int AW    = 10,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [AW-1:0]    in_addr,
   output logic [AW-1:0]    rd_addr,
   input  logic [CNT_W-1:0] rd_data,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [CNT_W-1:0] wr_data
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             s1_v;
   logic [AW-1:0]    s1_addr;
   logic             s1_fwd;
   logic [CNT_W-1:0] s1_fval;
   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] nxt;

   assign rd_addr = in_addr;
   assign base    = s1_fwd ? s1_fval : rd_data;
   assign nxt     = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;
   assign wr_en   = s1_v;
   assign wr_addr = s1_addr;
   assign wr_data = nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_addr <= '0;
         s1_fwd  <= 1'b0;
         s1_fval <= '0;
      end else begin
         s1_v    <= in_valid;
         s1_addr <= in_addr;
         s1_fwd  <= s1_v && in_valid && (s1_addr == in_addr);
         s1_fval <= nxt;
      end
   end

   // R5
   fwd_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && $past(wr_en) && (wr_addr == $past(wr_addr)) |->
         wr_data == (($past(wr_data) == CNT_MAX) ? CNT_MAX : $past(wr_data) + 1'b1));

   // R6
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_data != '0);
endmodule

// File: rtl/hist_readout.sv
module hist_readout import hist_pkg::*; #(
   parameter int RAW_BINS = 1024,
   parameter int AW       = 10,
   parameter int CAL_BINS = 800,
   parameter int CNT_W    = 16,
   parameter int WGT_W    = 8,
   parameter int OUT_W    = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tab_we,
   input  logic [AW-1:0]    tab_idx,
   input  logic             tab_step,
   input  logic [WGT_W-1:0] tab_wgt,
   input  logic             cal_en,
   input  logic             start,
   output logic [AW-1:0]    bank_addr,
   input  logic [CNT_W-1:0] bank_data,
   output logic             o_valid,
   output logic [AW-1:0]    o_idx,
   output logic [OUT_W-1:0] o_data,
   output logic             o_last
);
   localparam int KW = $clog2(RAW_BINS + 1);
   localparam logic [AW-1:0] LAST_RAW = AW'(RAW_BINS - 1);
   localparam logic [KW-1:0] CAL_N    = KW'(CAL_BINS);

   logic [RAW_BINS-1:0] step_q;
   logic [WGT_W-1:0]    wgt_q [RAW_BINS];

   ro_state_e        state;
   logic             issue_on, mode_q;
   logic [AW-1:0]    r;
   logic             p_v, p_step;
   logic [AW-1:0]    p_r;
   logic [WGT_W-1:0] p_w;
   logic [KW-1:0]    k;
   logic [OUT_W-1:0] acc_cur, acc_nxt;
   logic [CNT_W+WGT_W-1:0] prod;
   logic [CNT_W-1:0] a_part, b_part;

   function automatic logic [OUT_W-1:0] sadd(input logic [OUT_W-1:0] x, input logic [OUT_W-1:0] y);
      logic [OUT_W:0] s;
      s = {1'b0, x} + {1'b0, y};
      return s[OUT_W] ? '1 : s[OUT_W-1:0];
   endfunction

   always_ff @(posedge clk) begin
      if (tab_we) begin
         step_q[tab_idx] <= tab_step;
         wgt_q[tab_idx]  <= tab_wgt;
      end
   end

   assign bank_addr = r;
   assign prod   = {{WGT_W{1'b0}}, bank_data} * {{CNT_W{1'b0}}, p_w};
   assign a_part = CNT_W'(prod >> WGT_W);
   assign b_part = bank_data - a_part;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= RO_IDLE;
         issue_on <= 1'b0;
         mode_q   <= 1'b0;
         r        <= '0;
         p_v      <= 1'b0;
         p_r      <= '0;
         p_step   <= 1'b0;
         p_w      <= '0;
         k        <= '0;
         acc_cur  <= '0;
         acc_nxt  <= '0;
         o_valid  <= 1'b0;
         o_idx    <= '0;
         o_data   <= '0;
         o_last   <= 1'b0;
      end else begin
         o_valid <= 1'b0;
         o_last  <= 1'b0;
         p_v     <= issue_on;
         p_r     <= r;
         p_step  <= step_q[r];
         p_w     <= wgt_q[r];
         if (issue_on) begin
            r <= r + 1'b1;
            if (r == LAST_RAW) issue_on <= 1'b0;
         end
         case (state)
            RO_IDLE: begin
               if (start) begin
                  state    <= RO_SCAN;
                  issue_on <= 1'b1;
                  r        <= '0;
                  k        <= '0;
                  acc_cur  <= '0;
                  acc_nxt  <= '0;
                  mode_q   <= cal_en;
               end
            end
            RO_SCAN: begin
               if (p_v) begin
                  if (!mode_q) begin
                     o_valid <= 1'b1;
                     o_idx   <= p_r;
                     o_data  <= OUT_W'(bank_data);
                     o_last  <= (p_r == LAST_RAW);
                  end else if (p_step && (p_r != '0)) begin
                     if (k < CAL_N) begin
                        o_valid <= 1'b1;
                        o_idx   <= k[AW-1:0];
                        o_data  <= acc_cur;
                        o_last  <= (k == CAL_N - 1'b1);
                     end
                     k       <= k + 1'b1;
                     acc_cur <= sadd(acc_nxt, OUT_W'(a_part));
                     acc_nxt <= OUT_W'(b_part);
                  end else begin
                     acc_cur <= sadd(acc_cur, OUT_W'(a_part));
                     acc_nxt <= sadd(acc_nxt, OUT_W'(b_part));
                  end
                  if (p_r == LAST_RAW) state <= mode_q ? RO_FLUSH : RO_IDLE;
               end
            end
            RO_FLUSH: begin
               if (k < CAL_N) begin
                  o_valid <= 1'b1;
                  o_idx   <= k[AW-1:0];
                  o_data  <= acc_cur;
                  o_last  <= (k == CAL_N - 1'b1);
                  acc_cur <= acc_nxt;
                  acc_nxt <= '0;
                  k       <= k + 1'b1;
               end else begin
                  state <= RO_IDLE;
               end
            end
            default: state <= RO_IDLE;
         endcase
      end
   end

   // R8
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && $past(o_valid) && !$past(o_last) |-> o_idx == $past(o_idx) + 1'b1);

   // R9
   last_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && o_last |-> o_idx == (mode_q ? AW'(CAL_BINS - 1) : LAST_RAW));
endmodule

// File: rtl/hist_engine.sv
module hist_engine import hist_pkg::*; #(
   parameter int RAW_BINS  = 1024,
   parameter int CNT_W     = 16,
   parameter int N_CH      = 4,
   parameter int MAX_SHIFT = 4,
   parameter int CAL_BINS  = 800,
   parameter int WGT_W     = 8,
   parameter int OUT_W     = 20,
   localparam int AW   = $clog2(RAW_BINS),
   localparam int CH_W = $clog2(N_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ts_valid,
   input  logic [CH_W-1:0]  ts_chan,
   input  logic [AW-1:0]    ts_code,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [AW-1:0]    cfg_idx,
   input  logic [AW-1:0]    cfg_data,
   input  logic             cmd_clear,
   input  logic             cmd_swap,
   input  logic             rd_start,
   output logic             rd_valid,
   output logic [AW-1:0]    rd_idx,
   output logic [OUT_W-1:0] rd_data,
   output logic             rd_last
);
   localparam int SW = $clog2(MAX_SHIFT + 1);

   if (RAW_BINS != (1 << AW)) begin : g_chk_pow2
      $error("RAW_BINS must be a power of two");
   end
   if (N_CH < 2 || N_CH != (1 << CH_W)) begin : g_chk_ch
      $error("N_CH must be a power of two of at least 2");
   end
   if (MAX_SHIFT >= AW || MAX_SHIFT > 15) begin : g_chk_shift
      $error("MAX_SHIFT out of range");
   end
   if (CAL_BINS > RAW_BINS || CAL_BINS < 2) begin : g_chk_cal
      $error("CAL_BINS out of range");
   end
   if (AW < WGT_W + 1 || AW < 4) begin : g_chk_cfg
      $error("config data too narrow for table entries");
   end
   if (OUT_W < CNT_W) begin : g_chk_out
      $error("OUT_W narrower than a bin counter");
   end

   logic shift_we, off_we, tab_we;
   logic cal_en_q, active_q;

   assign shift_we = cfg_we && (cfg_sel == CFG_SHIFT);
   assign off_we   = cfg_we && (cfg_sel == CFG_OFFSET);
   assign tab_we   = cfg_we && (cfg_sel == CFG_CALTAB);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cal_en_q <= 1'b0;
         active_q <= 1'b0;
      end else begin
         if (cfg_we && (cfg_sel == CFG_MODE)) cal_en_q <= cfg_data[0];
         if (cmd_swap) active_q <= ~active_q;
      end
   end

   logic          bin_valid;
   logic [AW-1:0] bin_addr;

   hist_bin_map #(.AW(AW), .N_CH(N_CH), .CH_W(CH_W), .MAX_SHIFT(MAX_SHIFT), .SW(SW)) u_map (
      .clk(clk), .rst_n(rst_n),
      .shift_we(shift_we), .shift_req(cfg_data[3:0]),
      .off_we(off_we), .off_ch(cfg_idx[CH_W-1:0]), .off_val(cfg_data),
      .ts_valid(ts_valid), .ts_ch(ts_chan), .ts_code(ts_code),
      .bin_valid(bin_valid), .bin_addr(bin_addr)
   );

   logic [AW-1:0]    acc_ra, acc_wa, ro_ra;
   logic             acc_we;
   logic [CNT_W-1:0] acc_wd;
   logic [CNT_W-1:0] bank_rd [2];
   logic [AW-1:0]    bank_ra [2];
   logic [1:0]       bank_clr;

   hist_accum #(.AW(AW), .CNT_W(CNT_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .in_valid(bin_valid), .in_addr(bin_addr),
      .rd_addr(acc_ra), .rd_data(bank_rd[active_q]),
      .wr_en(acc_we), .wr_addr(acc_wa), .wr_data(acc_wd)
   );

   for (genvar b = 0; b < 2; b++) begin : g_bank
      assign bank_ra[b]  = (active_q == 1'(b)) ? acc_ra : ro_ra;
      assign bank_clr[b] = (cmd_clear && (active_q == 1'(b))) ||
                           (cmd_swap  && (active_q != 1'(b)));
      hist_bank #(.DEPTH(RAW_BINS), .AW(AW), .CNT_W(CNT_W)) u_bank (
         .clk(clk), .rst_n(rst_n), .clr(bank_clr[b]),
         .rd_addr(bank_ra[b]), .rd_data(bank_rd[b]),
         .wr_en(acc_we && (active_q == 1'(b))), .wr_addr(acc_wa), .wr_data(acc_wd)
      );
   end

   hist_readout #(.RAW_BINS(RAW_BINS), .AW(AW), .CAL_BINS(CAL_BINS), .CNT_W(CNT_W),
                  .WGT_W(WGT_W), .OUT_W(OUT_W)) u_ro (
      .clk(clk), .rst_n(rst_n),
      .tab_we(tab_we), .tab_idx(cfg_idx), .tab_step(cfg_data[WGT_W]), .tab_wgt(cfg_data[WGT_W-1:0]),
      .cal_en(cal_en_q), .start(rd_start),
      .bank_addr(ro_ra), .bank_data(bank_rd[~active_q]),
      .o_valid(rd_valid), .o_idx(rd_idx), .o_data(rd_data), .o_last(rd_last)
   );
endmodule

// File: tb/sim_hist_engine.sv
module sim_hist_engine;
   localparam int NB = 1024;
   localparam int NC = 800;
   localparam int CMAX = 65535;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ts_valid = 1'b0;
   logic [1:0] ts_chan = '0;
   logic [9:0] ts_code = '0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_sel = '0;
   logic [9:0] cfg_idx = '0;
   logic [9:0] cfg_data = '0;
   logic cmd_clear = 1'b0, cmd_swap = 1'b0, rd_start = 1'b0;
   logic rd_valid, rd_last;
   logic [9:0] rd_idx;
   logic [19:0] rd_data;

   always #10 clk = ~clk;

   hist_engine u0 (
      .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_chan(ts_chan), .ts_code(ts_code),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .cmd_clear(cmd_clear), .cmd_swap(cmd_swap), .rd_start(rd_start),
      .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data), .rd_last(rd_last)
   );

   int act[NB];
   int ina[NB];
   int off[4];
   int shift = 0;
   bit cal_mode = 0;
   bit tstep[NB];
   int twgt[NB];
   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   string tag = "R1";

   int q_idx[$];
   int q_dat[$];
   bit q_last[$];

   task automatic fail(string req, string what, int a, int e);
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, a, e);
   endtask

   // per-cycle comparison of the read-out stream against the model queue
   always @(negedge clk) begin
      if (rst_n && !finished && rd_valid) begin
         n_chk++;
         if (q_idx.size() == 0) begin
            fail(tag, "unexpected beat idx", int'(rd_idx), -1);
         end else begin
            int ei, ed;
            bit el;
            ei = q_idx.pop_front();
            ed = q_dat.pop_front();
            el = q_last.pop_front();
            if (int'(rd_idx) != ei) fail(tag, "beat index", int'(rd_idx), ei);
            else if (int'(rd_data) != ed) fail(tag, $sformatf("data at bin %0d", ei), int'(rd_data), ed);
            else if (rd_last != el) fail(tag, $sformatf("last flag at bin %0d", ei), int'(rd_last), int'(el));
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic cfg(int sel, int idx, int data);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = 10'(idx); cfg_data = 10'(data);
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic set_shift(int req);
      cfg(0, 0, req);
      shift = (req > 4) ? 4 : req;
   endtask

   task automatic set_off(int ch, int o);
      cfg(1, ch, o & 1023);
      off[ch] = o;
   endtask

   task automatic set_mode(bit c);
      cfg(3, 0, int'(c));
      cal_mode = c;
   endtask

   // one hit per call, ts_valid left high so calls can be back to back
   task automatic hit(int ch, int code);
      int adj;
      ts_valid = 1'b1; ts_chan = 2'(ch); ts_code = 10'(code);
      tick();
      adj = (((code + off[ch]) % NB) + NB) % NB;
      adj = adj >> shift;
      if (act[adj] < CMAX) act[adj]++;
   endtask

   task automatic hits_done();
      ts_valid = 1'b0;
      idle(4);
   endtask

   task automatic do_swap();
      idle(4);
      cmd_swap = 1'b1; tick(); cmd_swap = 1'b0;
      for (int i = 0; i < NB; i++) begin ina[i] = act[i]; act[i] = 0; end
      idle(2);
   endtask

   task automatic do_clear();
      idle(4);
      cmd_clear = 1'b1; tick(); cmd_clear = 1'b0;
      for (int i = 0; i < NB; i++) act[i] = 0;
      idle(2);
   endtask

   task automatic start_pass(string t);
      tag = t;
      if (!cal_mode) begin
         for (int i = 0; i < NB; i++) begin
            q_idx.push_back(i); q_dat.push_back(ina[i]); q_last.push_back(i == NB - 1);
         end
      end else begin
         int cal[NC + 1];
         int ci;
         for (int i = 0; i <= NC; i++) cal[i] = 0;
         ci = 0;
         for (int r = 0; r < NB; r++) begin
            int a, b;
            if (r > 0 && tstep[r]) ci++;
            a = (ina[r] * twgt[r]) / 256;
            b = ina[r] - a;
            if (ci < NC) cal[ci] += a;
            if (ci + 1 < NC) cal[ci + 1] += b;
         end
         for (int i = 0; i < NC; i++) begin
            q_idx.push_back(i); q_dat.push_back(cal[i]); q_last.push_back(i == NC - 1);
         end
      end
      rd_start = 1'b1; tick(); rd_start = 1'b0;
   endtask

   task automatic wait_pass();
      for (int i = 0; i < 3000 && q_idx.size() != 0; i++) tick();
      n_chk++;
      if (q_idx.size() != 0) fail(tag, "beats missing", NB - q_idx.size(), NB);
      idle(4);
      q_idx.delete(); q_dat.delete(); q_last.delete();
   endtask

   initial begin
      #(20 * 190000);
      n_fail++;
      $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NB; i++) begin act[i] = 0; ina[i] = 0; end
      for (int i = 0; i < 4; i++) off[i] = 0;
      idle(3);
      rst_n = 1'b1;
      idle(3);

      // R1: idle output after reset, empty banks, raw mode
      for (int i = 0; i < 5; i++) begin
         n_chk++;
         if (rd_valid !== 1'b0) fail("R1", "rd_valid after reset", int'(rd_valid), 0);
         tick();
      end
      start_pass("R1"); wait_pass();
      do_swap();
      start_pass("R1"); wait_pass();

      // calibration table: step 0 set on purpose (must be ignored), last index 799
      for (int r = 0; r < NB; r++) begin
         tstep[r] = (r == 0) ? 1'b1 : (((r * 25) / 32) != (((r - 1) * 25) / 32));
         twgt[r] = (r * 37 + 11) % 256;
         cfg(2, r, (int'(tstep[r]) << 8) | twgt[r]);
      end

      // R2 and R5: plain hits and back-to-back hits to one bin
      hit(0, 5); hit(0, 5); hit(0, 5); hit(0, 7); hit(1, 1023); hit(0, 5);
      for (int i = 0; i < 6; i++) hit(2, (i % 2) ? 9 : 8);
      hit(3, 0);
      hits_done();
      do_swap();
      start_pass("R5"); wait_pass();

      // R3 and R4: offsets with wrap, merge shift, clamp of an oversized shift
      set_off(1, 300); set_off(2, -300); set_off(3, 1000);
      set_shift(2);
      hit(0, 17); hit(1, 900); hit(2, 100); hit(3, 50); hit(3, 24); hit(2, 299); hit(1, 723);
      hits_done();
      set_shift(9);
      hit(0, 1023); hit(1, 5); hit(2, 0); hit(0, 31); hit(0, 32);
      hits_done();
      do_swap();
      start_pass("R4"); wait_pass();

      // R7: clear wipes the collecting bank only
      set_shift(0);
      for (int i = 0; i < 4; i++) set_off(i, 0);
      hit(0, 40); hit(0, 41); hit(1, 600);
      hits_done();
      do_clear();
      hit(0, 41); hit(2, 602);
      hits_done();
      do_swap();
      start_pass("R7"); wait_pass();

      // R10 and R11: hits and a second start during a pass
      hit(0, 200); hit(0, 201); hit(0, 201);
      hits_done();
      do_swap();
      start_pass("R10");
      for (int i = 0; i < 300; i++) hit(i % 4, (i * 13) % NB);
      ts_valid = 1'b0;
      rd_start = 1'b1; tick(); rd_start = 1'b0;
      wait_pass();
      idle(1100);
      n_chk++;
      if (rd_valid !== 1'b0) fail("R11", "second pass started", int'(rd_valid), 0);
      do_swap();
      start_pass("R10"); wait_pass();

      // R9: calibrated read-out
      set_mode(1'b1);
      for (int i = 0; i < 3000; i++) hit(0, (i * 7 + i / 5) % NB);
      for (int i = 0; i < 40; i++) hit(1, 1023);
      hits_done();
      do_swap();
      start_pass("R9"); wait_pass();

      // R6: saturation of a bin counter
      set_mode(1'b0);
      for (int i = 0; i < 65540; i++) hit(0, 100);
      hit(0, 101); hit(0, 101); hit(0, 101);
      hits_done();
      do_swap();
      start_pass("R6"); wait_pass();

      // R8: raw pass index order and last flag already compared beat by beat
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule